// File: doc/BRIEF.md
# Single-Channel Control-Structure DMA Sequencer

This block moves a run of data items from a source region to a destination region for one DMA channel. It works from two control structures, a primary and an alternate, held in a small local table that software fills through a plain configuration write port. Each structure holds an end address for the source, an end address for the destination and a control word. The control word gives the mode, the item size, the two address steps, the burst length and the number of items still to move, stored as that number minus one. The engine derives each current address from the end address and the items still to move, so it never stores a start address.

Software loads a structure, pulses `chan_start` to enable the channel, and then either a peripheral holds `periph_req` high or software pulses `sw_req`. The engine fetches the active structure, moves items over a single valid/ready memory port, and after every item writes the decremented count back into the table. When the last item of a structure has moved, the engine rewrites that control word to the stop state and pulses `done`. Basic and auto modes then disable the channel. Ping-pong mode switches to the other structure and keeps going, which lets software refill the structure that is idle. The channel stops when the engine switches onto a structure that is in the stop state.

On the memory port, a request is held with its address, direction, size and write data unchanged until `mem_ready` is high at a clock edge. The engine accepts a read response only while it is waiting for one, and it never stalls the response path. Each accepted read must be answered by exactly one `mem_rsp_valid` pulse.

Top module: `dma_struct_engine`

## Requirements
- R1: After reset the channel is disabled, `mem_valid`, `done` and `err` are low, and every table word reads back as zero.
- R2: Control word fields are mode [2:0], count [13:4], burst code [17:14], item size [25:24], source step [27:26] and destination step [31:30]. Mode values: 0 stop, 1 basic, 2 auto, 3 ping-pong. Size codes 0/1/2 are 8/16/32 bits. Step codes 0/1/2 are 1/2/4 bytes and 3 means a fixed address. For a structure of N items with end address E and step s, item k is at E - (N << s) + 1 + (k << s), or at E when s is 3.
- R3: After each item that is not the last, the count field in the table drops by one, so the items remaining equal the field plus one. When a structure finishes, bits [13:0] of its control word read zero and the other bits are unchanged.
- R4: Basic mode starts a burst only when `periph_req` is high or a `sw_req` pulse is pending. A burst runs to its end even if the request drops.
- R5: Auto mode, once started, runs to completion with no further request.
- R6: A burst is 2^code items, with any code above 10 treated as 10. Once a burst ends, the engine goes back through arbitration before it moves the next item.
- R7: The completion of a structure gives a one-cycle `done` pulse. In basic and auto mode, `chan_en` drops in the same cycle.
- R8: In ping-pong mode, the completion of one structure makes the engine fetch the other one at once. If that structure is in stop mode, the channel disables with no `err`, and `alt_active` keeps pointing at it.
- R9: If the first fetch after enabling finds mode stop, a mode above 3, size code 3, or a non-fixed step smaller than the item size, the engine pulses `err`, disables the channel and makes no memory request.
- R10: While the channel is disabled, `periph_req` and `sw_req` have no effect: no memory request is made, no table word changes, and a `sw_req` given while disabled is not remembered.
- R11: A memory request holds steady until accepted. The write data is the read item masked to the item size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 1 | Structure written: 0 primary, 1 alternate |
| cfg_word | input | 2 | Word written: 0 source end, 1 destination end, 2 control |
| cfg_wdata | input | 32 | Table write data |
| cfg_rsel | input | 1 | Structure read back |
| cfg_rword | input | 2 | Word read back (3 reads zero) |
| cfg_rdata | output | 32 | Read-back data, combinational |
| chan_start | input | 1 | Pulse: enable the channel, starting at the primary structure |
| chan_en | output | 1 | Channel enabled |
| alt_active | output | 1 | Structure in use: 0 primary, 1 alternate |
| periph_req | input | 1 | Peripheral request level |
| sw_req | input | 1 | Software request pulse |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_write | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Byte address |
| mem_size | output | 2 | Item size code |
| mem_wdata | output | DATA_W | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | DATA_W | Read data, item in the low bits |
| done | output | 1 | Structure completion pulse |
| err | output | 1 | Illegal structure pulse |

## Verification
The properties assume a memory side that answers each accepted read with exactly one response pulse and never sends a response at any other time. They also assume that software rewrites only the structure that is not in use. The bench's memory model produces one response, one cycle after each read it accepts, and it can stall requests with a random `mem_ready`. Table rewrites in the ping-pong test are timed to the completion pulse of the structure being refilled, so they always land while the engine is using the other structure.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  localparam int CFG_W    = 32;
  localparam int CNT_W    = 10;
  localparam int NSTRUCT  = 2;
  localparam int ARB_MAX  = 10;

  localparam logic [2:0] MD_STOP  = 3'd0;
  localparam logic [2:0] MD_BASIC = 3'd1;
  localparam logic [2:0] MD_AUTO  = 3'd2;
  localparam logic [2:0] MD_PING  = 3'd3;

  localparam logic [1:0] STEP_FIXED = 2'd3;

  localparam logic [1:0] W_SRC  = 2'd0;
  localparam logic [1:0] W_DST  = 2'd1;
  localparam logic [1:0] W_CTRL = 2'd2;

  typedef struct packed {
    logic [1:0]       dstep;
    logic [1:0]       rsv_a;
    logic [1:0]       sstep;
    logic [1:0]       isize;
    logic [5:0]       rsv_b;
    logic [3:0]       arb;
    logic [CNT_W-1:0] cnt;
    logic             rsv_c;
    logic [2:0]       mode;
  } ctrl_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_RD, ST_RW, ST_WR, ST_NEXT
  } eng_state_e;

  function automatic logic step_ok(logic [1:0] step, logic [1:0] isize);
    return (step == STEP_FIXED) || (step >= isize);
  endfunction

  function automatic logic ctrl_legal(ctrl_t c);
    logic mode_ok;
    mode_ok = (c.mode == MD_BASIC) || (c.mode == MD_AUTO) || (c.mode == MD_PING);
    return mode_ok && (c.isize != 2'd3) && step_ok(c.sstep, c.isize) &&
           step_ok(c.dstep, c.isize);
  endfunction
endpackage

// File: rtl/dmx_table.sv
module dmx_table import dmx_pkg::*; #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [1:0]        cfg_word,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              wb_en,
  input  logic              wb_sel,
  input  ctrl_t             wb_ctrl,
  input  logic              eng_sel,
  output logic [ADDR_W-1:0] eng_src_end,
  output logic [ADDR_W-1:0] eng_dst_end,
  output ctrl_t             eng_ctrl,
  input  logic              rd_sel,
  input  logic [1:0]        rd_word,
  output logic [CFG_W-1:0]  rd_data
);
  logic [ADDR_W-1:0] src_q  [NSTRUCT];
  logic [ADDR_W-1:0] dst_q  [NSTRUCT];
  ctrl_t             ctrl_q [NSTRUCT];

  for (genvar s = 0; s < NSTRUCT; s++) begin : g_struct
    logic cfg_hit;
    logic wb_hit;
    assign cfg_hit = cfg_we && (cfg_sel == 1'(s));
    assign wb_hit  = wb_en && (wb_sel == 1'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_q[s]  <= '0;
        dst_q[s]  <= '0;
        ctrl_q[s] <= '0;
      end else begin
        if (cfg_hit && cfg_word == W_SRC) src_q[s] <= cfg_wdata[ADDR_W-1:0];
        if (cfg_hit && cfg_word == W_DST) dst_q[s] <= cfg_wdata[ADDR_W-1:0];
        // engine write-back wins over a software write of the same word
        if (wb_hit)                             ctrl_q[s] <= wb_ctrl;
        else if (cfg_hit && cfg_word == W_CTRL) ctrl_q[s] <= ctrl_t'(cfg_wdata);
      end
    end
  end

  assign eng_src_end = src_q[eng_sel];
  assign eng_dst_end = dst_q[eng_sel];
  assign eng_ctrl    = ctrl_q[eng_sel];

  always_comb begin
    case (rd_word)
      W_SRC:   rd_data = CFG_W'(src_q[rd_sel]);
      W_DST:   rd_data = CFG_W'(dst_q[rd_sel]);
      W_CTRL:  rd_data = CFG_W'(ctrl_q[rd_sel]);
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/dmx_addr.sv
module dmx_addr import dmx_pkg::*; #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] end_addr,
  input  logic [1:0]        step,
  input  logic [CNT_W-1:0]  cnt,
  output logic [ADDR_W-1:0] addr
);
  logic [CNT_W:0]    remain;
  logic [ADDR_W-1:0] span;

  always_comb begin
    remain = {1'b0, cnt} + (CNT_W+1)'(1);
    span   = ADDR_W'(remain) << step;
    addr   = (step == STEP_FIXED) ? end_addr : (end_addr - span + ADDR_W'(1));
  end
endmodule

// File: rtl/dma_struct_engine.sv
module dma_struct_engine import dmx_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [1:0]        cfg_word,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              cfg_rsel,
  input  logic [1:0]        cfg_rword,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              chan_start,
  output logic              chan_en,
  output logic              alt_active,
  input  logic              periph_req,
  input  logic              sw_req,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              done,
  output logic              err
);
  localparam int NPTR = 2;

  eng_state_e        state_q;
  logic              en_q, alt_q, sw_pend_q, run_auto_q, chained_q;
  logic              done_q, err_q;
  ctrl_t             cur_q;
  logic [ADDR_W-1:0] src_end_q, dst_end_q;
  logic [CNT_W:0]    bcnt_q;
  logic [DATA_W-1:0] data_q;

  logic [ADDR_W-1:0] t_src_end, t_dst_end;
  ctrl_t             t_ctrl;
  logic              wb_en;
  ctrl_t             wb_ctrl;

  logic [ADDR_W-1:0] ptr_end  [NPTR];
  logic [1:0]        ptr_step [NPTR];
  logic [ADDR_W-1:0] ptr_addr [NPTR];

  logic              req_now;
  logic              last_item;
  logic              burst_end;
  logic [CNT_W:0]    arb_lim;
  logic [DATA_W-1:0] item_mask;

  dmx_table #(.ADDR_W(ADDR_W)) i_table (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_sel     (cfg_sel),
    .cfg_word    (cfg_word),
    .cfg_wdata   (cfg_wdata),
    .wb_en       (wb_en),
    .wb_sel      (alt_q),
    .wb_ctrl     (wb_ctrl),
    .eng_sel     (alt_q),
    .eng_src_end (t_src_end),
    .eng_dst_end (t_dst_end),
    .eng_ctrl    (t_ctrl),
    .rd_sel      (cfg_rsel),
    .rd_word     (cfg_rword),
    .rd_data     (cfg_rdata)
  );

  assign ptr_end[0]  = src_end_q;
  assign ptr_end[1]  = dst_end_q;
  assign ptr_step[0] = cur_q.sstep;
  assign ptr_step[1] = cur_q.dstep;

  for (genvar p = 0; p < NPTR; p++) begin : g_ptr
    dmx_addr #(.ADDR_W(ADDR_W)) i_addr (
      .end_addr (ptr_end[p]),
      .step     (ptr_step[p]),
      .cnt      (cur_q.cnt),
      .addr     (ptr_addr[p])
    );
  end

  assign req_now   = periph_req || sw_pend_q;
  assign last_item = (cur_q.cnt == '0);
  assign arb_lim   = (cur_q.arb >= 4'(ARB_MAX)) ? (CNT_W+1)'(1) << ARB_MAX
                                                 : (CNT_W+1)'(1) << cur_q.arb;
  assign burst_end = ((bcnt_q + (CNT_W+1)'(1)) == arb_lim);

  always_comb begin
    case (cur_q.isize)
      2'd0:    item_mask = DATA_W'(8'hFF);
      2'd1:    item_mask = DATA_W'(16'hFFFF);
      default: item_mask = '1;
    endcase
  end

  // write-back of the active control word after each item
  always_comb begin
    wb_en   = (state_q == ST_NEXT);
    wb_ctrl = cur_q;
    if (last_item) wb_ctrl.mode = MD_STOP;
    else           wb_ctrl.cnt  = cur_q.cnt - CNT_W'(1);
  end

  always_comb begin
    mem_valid = 1'b0;
    mem_write = 1'b0;
    mem_addr  = ptr_addr[0];
    case (state_q)
      ST_RD: mem_valid = 1'b1;
      ST_WR: begin
        mem_valid = 1'b1;
        mem_write = 1'b1;
        mem_addr  = ptr_addr[1];
      end
      default: ;
    endcase
  end

  assign mem_size   = cur_q.isize;
  assign mem_wdata  = data_q;
  assign chan_en    = en_q;
  assign alt_active = alt_q;
  assign done       = done_q;
  assign err        = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      en_q       <= 1'b0;
      alt_q      <= 1'b0;
      sw_pend_q  <= 1'b0;
      run_auto_q <= 1'b0;
      chained_q  <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      cur_q      <= '0;
      src_end_q  <= '0;
      dst_end_q  <= '0;
      bcnt_q     <= '0;
      data_q     <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;

      if (chan_start && !en_q) begin
        en_q       <= 1'b1;
        alt_q      <= 1'b0;
        sw_pend_q  <= 1'b0;
        run_auto_q <= 1'b0;
        chained_q  <= 1'b0;
      end

      case (state_q)
        ST_IDLE: begin
          if (en_q && (req_now || run_auto_q)) state_q <= ST_LOAD;
        end

        ST_LOAD: begin
          cur_q     <= t_ctrl;
          src_end_q <= t_src_end;
          dst_end_q <= t_dst_end;
          bcnt_q    <= '0;
          sw_pend_q <= 1'b0;
          chained_q <= 1'b0;
          if (chained_q && t_ctrl.mode == MD_STOP) begin
            // ping-pong ran onto an idle structure: orderly end
            en_q       <= 1'b0;
            run_auto_q <= 1'b0;
            state_q    <= ST_IDLE;
          end else if (!ctrl_legal(t_ctrl)) begin
            err_q      <= 1'b1;
            en_q       <= 1'b0;
            run_auto_q <= 1'b0;
            state_q    <= ST_IDLE;
          end else begin
            if (t_ctrl.mode == MD_AUTO) run_auto_q <= 1'b1;
            state_q <= ST_RD;
          end
        end

        ST_RD: begin
          if (mem_ready) state_q <= ST_RW;
        end

        ST_RW: begin
          if (mem_rsp_valid) begin
            data_q  <= mem_rsp_data & item_mask;
            state_q <= ST_WR;
          end
        end

        ST_WR: begin
          if (mem_ready) state_q <= ST_NEXT;
        end

        ST_NEXT: begin
          if (last_item) begin
            done_q <= 1'b1;
            if (cur_q.mode == MD_PING) begin
              alt_q     <= ~alt_q;
              chained_q <= 1'b1;
              state_q   <= ST_LOAD;
            end else begin
              en_q       <= 1'b0;
              run_auto_q <= 1'b0;
              sw_pend_q  <= 1'b0;
              state_q    <= ST_IDLE;
            end
          end else begin
            cur_q.cnt <= cur_q.cnt - CNT_W'(1);
            bcnt_q    <= bcnt_q + (CNT_W+1)'(1);
            state_q   <= burst_end ? ST_IDLE : ST_RD;
          end
        end

        default: state_q <= ST_IDLE;
      endcase

      if (sw_req && en_q) sw_pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dmx_check.sv
module dmx_check #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_write,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [1:0]        mem_size,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              chan_en,
  input logic              done,
  input logic              err
);
  assert_hold_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) &&
                                $stable(mem_write) && $stable(mem_wdata) &&
                                $stable(mem_size));

  assert_size_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_size != 2'd3);

  assert_quiet_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |-> !mem_valid);

  assert_err_disables_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !chan_en && !mem_valid);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_err_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
endmodule

bind dma_struct_engine dmx_check #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_write (mem_write),
  .mem_addr  (mem_addr),
  .mem_size  (mem_size),
  .mem_wdata (mem_wdata),
  .chan_en   (chan_en),
  .done      (done),
  .err       (err)
);

// File: tb/test_dma_struct_engine.sv
module test_dma_struct_engine;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0, cfg_rsel = 1'b0;
  logic [1:0]  cfg_word = '0, cfg_rword = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        chan_start = 1'b0, chan_en, alt_active;
  logic        periph_req = 1'b0, sw_req = 1'b0;
  logic        mem_valid, mem_write, mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata;
  logic [1:0]  mem_size;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done, err;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_struct_engine i_dma_struct_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_word(cfg_word), .cfg_wdata(cfg_wdata), .cfg_rsel(cfg_rsel),
    .cfg_rword(cfg_rword), .cfg_rdata(cfg_rdata), .chan_start(chan_start),
    .chan_en(chan_en), .alt_active(alt_active), .periph_req(periph_req),
    .sw_req(sw_req), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_write(mem_write), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .err(err)
  );

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [1:0]  size;
    logic [31:0] data;
  } txn_t;

  txn_t   exp_q[$];
  integer checks = 0, errs = 0, cyc = 0;
  integer n_done = 0, n_err = 0;
  logic   bp_on = 1'b0;
  logic   pend_rd = 1'b0;
  logic [31:0] pend_addr = '0;

  function automatic logic [31:0] rdpat(logic [31:0] a);
    return {a[7:0] ^ 8'h3C, a[7:0], ~a[7:0], a[7:0] + 8'h11};
  endfunction

  function automatic logic [31:0] szmask(logic [1:0] s);
    return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // memory model and reference comparison, evaluated away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (done) n_done++;
    if (err)  n_err++;
    mem_rsp_valid = pend_rd;
    mem_rsp_data  = pend_rd ? rdpat(pend_addr) : 32'h0;
    pend_rd       = 1'b0;
    mem_ready     = bp_on ? (($urandom % 3) != 0) : 1'b1;
    if (rst_n && mem_valid && mem_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 unexpected memory request", mem_addr, 32'h0);
      end else begin
        txn_t t;
        t = exp_q.pop_front();
        chk(mem_write == t.wr, "R2 request direction", 32'(mem_write), 32'(t.wr));
        chk(mem_addr == t.addr, "R2 request address", mem_addr, t.addr);
        chk(mem_size == t.size, "R2 request size", 32'(mem_size), 32'(t.size));
        if (t.wr) chk(mem_wdata == t.data, "R11 write data", mem_wdata, t.data);
      end
      if (!mem_write) begin
        pend_rd   = 1'b1;
        pend_addr = mem_addr;
      end
    end
    if (cyc > WATCHDOG) begin
      chk(1'b0, "R7 watchdog expired", 32'(cyc), 32'(WATCHDOG));
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic cfg_write(input logic sel, input logic [1:0] word, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_word = word; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic tbl_read(input logic sel, input logic [1:0] word, output logic [31:0] d);
    cfg_rsel = sel; cfg_rword = word;
    #1;
    d = cfg_rdata;
  endtask

  function automatic logic [31:0] mk_ctrl(input int n, input logic [1:0] size,
      input logic [1:0] sinc, input logic [1:0] dinc, input logic [3:0] arb,
      input logic [2:0] mode);
    return (32'(dinc) << 30) | (32'(sinc) << 26) | (32'(size) << 24) |
           (32'(arb) << 14) | (32'(n - 1) << 4) | 32'(mode);
  endfunction

  function automatic logic [31:0] end_of(input logic [31:0] start, input int n,
                                         input logic [1:0] inc);
    return (inc == 2'd3) ? start : start + (32'(n) << inc) - 32'd1;
  endfunction

  task automatic setup(input logic sel, input logic [31:0] s0, input logic [31:0] d0,
      input int n, input logic [1:0] size, input logic [1:0] sinc,
      input logic [1:0] dinc, input logic [3:0] arb, input logic [2:0] mode);
    cfg_write(sel, 2'd0, end_of(s0, n, sinc));
    cfg_write(sel, 2'd1, end_of(d0, n, dinc));
    cfg_write(sel, 2'd2, mk_ctrl(n, size, sinc, dinc, arb, mode));
  endtask

  task automatic expect_items(input logic [31:0] s0, input logic [31:0] d0,
      input int first, input int cnt, input logic [1:0] size,
      input logic [1:0] sinc, input logic [1:0] dinc);
    for (int k = first; k < first + cnt; k++) begin
      logic [31:0] sa, da;
      txn_t t;
      sa = (sinc == 2'd3) ? s0 : s0 + (32'(k) << sinc);
      da = (dinc == 2'd3) ? d0 : d0 + (32'(k) << dinc);
      t.wr = 1'b0; t.addr = sa; t.size = size; t.data = 32'h0;
      exp_q.push_back(t);
      t.wr = 1'b1; t.addr = da; t.size = size; t.data = rdpat(sa) & szmask(size);
      exp_q.push_back(t);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); chan_start = 1'b1;
    @(negedge clk); chan_start = 1'b0;
  endtask

  task automatic pulse_sw();
    @(negedge clk); sw_req = 1'b1;
    @(negedge clk); sw_req = 1'b0;
  endtask

  task automatic wait_off(input string tag);
    int i;
    i = 0;
    while (chan_en && i < 4000) begin
      @(negedge clk);
      i++;
    end
    chk(!chan_en, tag, 32'(chan_en), 32'h0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] rd;
    int d0, e0;

    idle(3);
    // R1: reset state
    chk(chan_en == 1'b0, "R1 channel disabled", 32'(chan_en), 32'h0);
    chk(mem_valid == 1'b0 && done == 1'b0 && err == 1'b0, "R1 outputs quiet",
        {29'h0, mem_valid, done, err}, 32'h0);
    tbl_read(1'b0, 2'd2, rd);
    chk(rd == 32'h0, "R1 primary control zero", rd, 32'h0);
    rst_n = 1'b1;
    idle(2);
    tbl_read(1'b1, 2'd0, rd);
    chk(rd == 32'h0, "R1 alternate source end zero", rd, 32'h0);

    // T1: basic, byte items and byte steps, request held (R2 R3 R7)
    setup(1'b0, 32'h100, 32'h200, 5, 2'd0, 2'd0, 2'd0, 4'd3, 3'd1);
    expect_items(32'h100, 32'h200, 0, 5, 2'd0, 2'd0, 2'd0);
    d0 = n_done;
    pulse_start();
    periph_req = 1'b1;
    wait_off("R7 basic run ends disabled");
    periph_req = 1'b0;
    idle(2);
    chk(exp_q.size() == 0, "R2 all basic items seen", 32'(exp_q.size()), 32'h0);
    chk(n_done == d0 + 1, "R7 one done pulse", 32'(n_done - d0), 32'h1);
    tbl_read(1'b0, 2'd2, rd);
    chk(rd == (mk_ctrl(5, 2'd0, 2'd0, 2'd0, 4'd3, 3'd1) & ~32'h3FFF),
        "R3 finished control word", rd, mk_ctrl(5, 2'd0, 2'd0, 2'd0, 4'd3, 3'd1) & ~32'h3FFF);

    // T2: auto, words, fixed destination, bursts of one, back-pressure (R5 R6 R11)
    bp_on = 1'b1;
    setup(1'b0, 32'h340, 32'h480, 4, 2'd2, 2'd2, 2'd3, 4'd0, 3'd2);
    expect_items(32'h340, 32'h480, 0, 4, 2'd2, 2'd2, 2'd3);
    pulse_start();
    pulse_sw();
    wait_off("R5 auto runs to completion");
    idle(2);
    chk(exp_q.size() == 0, "R5 auto items all seen", 32'(exp_q.size()), 32'h0);
    bp_on = 1'b0;

    // T3: basic bursts of two, halfwords, request dropped early (R4 R6 R3)
    setup(1'b0, 32'h520, 32'h600, 6, 2'd1, 2'd1, 2'd2, 4'd1, 3'd1);
    expect_items(32'h520, 32'h600, 0, 2, 2'd1, 2'd1, 2'd2);
    pulse_start();
    @(negedge clk); periph_req = 1'b1;
    @(negedge clk); periph_req = 1'b0;
    idle(60);
    chk(exp_q.size() == 0, "R6 first burst of two moved", 32'(exp_q.size()), 32'h0);
    tbl_read(1'b0, 2'd2, rd);
    chk(rd[13:4] == 10'd3, "R3 count field after burst", 32'(rd[13:4]), 32'd3);
    chk(32'(rd[13:4]) + 1 == 4, "R3 remaining items", 32'(rd[13:4]) + 1, 32'd4);
    chk(chan_en == 1'b1, "R4 channel waits for request", 32'(chan_en), 32'h1);
    expect_items(32'h520, 32'h600, 2, 2, 2'd1, 2'd1, 2'd2);
    pulse_sw();
    idle(60);
    chk(exp_q.size() == 0, "R4 software burst moved", 32'(exp_q.size()), 32'h0);
    tbl_read(1'b0, 2'd2, rd);
    chk(rd[13:4] == 10'd1, "R4 count after software burst", 32'(rd[13:4]), 32'd1);
    expect_items(32'h520, 32'h600, 4, 2, 2'd1, 2'd1, 2'd2);
    periph_req = 1'b1;
    wait_off("R4 basic finishes");
    periph_req = 1'b0;
    idle(2);
    chk(exp_q.size() == 0, "R4 last burst moved", 32'(exp_q.size()), 32'h0);

    // T4: ping-pong with refill of the idle primary (R8)
    setup(1'b0, 32'h700, 32'h780, 3, 2'd2, 2'd2, 2'd2, 4'd3, 3'd3);
    setup(1'b1, 32'h800, 32'h880, 2, 2'd0, 2'd0, 2'd1, 4'd3, 3'd3);
    expect_items(32'h700, 32'h780, 0, 3, 2'd2, 2'd2, 2'd2);
    expect_items(32'h800, 32'h880, 0, 2, 2'd0, 2'd0, 2'd1);
    expect_items(32'h900, 32'h980, 0, 2, 2'd1, 2'd1, 2'd1);
    d0 = n_done;
    pulse_start();
    periph_req = 1'b1;
    while (n_done == d0) @(negedge clk);
    chk(alt_active == 1'b1, "R8 switched to alternate", 32'(alt_active), 32'h1);
    setup(1'b0, 32'h900, 32'h980, 2, 2'd1, 2'd1, 2'd1, 4'd3, 3'd1);
    wait_off("R8 ping-pong chain ends");
    periph_req = 1'b0;
    idle(2);
    chk(exp_q.size() == 0, "R8 both structures and refill moved", 32'(exp_q.size()), 32'h0);
    chk(n_done == d0 + 3, "R8 three completions", 32'(n_done - d0), 32'h3);
    chk(alt_active == 1'b0, "R8 back on primary", 32'(alt_active), 32'h0);

    // T5: ping-pong onto a stopped alternate (R8)
    cfg_write(1'b1, 2'd2, 32'h0);
    setup(1'b0, 32'hA00, 32'hA40, 2, 2'd2, 2'd2, 2'd2, 4'd2, 3'd3);
    expect_items(32'hA00, 32'hA40, 0, 2, 2'd2, 2'd2, 2'd2);
    d0 = n_done; e0 = n_err;
    pulse_start();
    periph_req = 1'b1;
    wait_off("R8 stop structure disables");
    periph_req = 1'b0;
    idle(2);
    chk(exp_q.size() == 0, "R8 primary moved before stop", 32'(exp_q.size()), 32'h0);
    chk(n_done == d0 + 1 && n_err == e0, "R8 one done no error",
        32'(n_done - d0), 32'h1);
    chk(alt_active == 1'b1, "R8 left on stopped structure", 32'(alt_active), 32'h1);

    // T6: illegal structures (R9)
    for (int c = 0; c < 3; c++) begin
      logic [31:0] bad;
      bad = (c == 0) ? mk_ctrl(4, 2'd0, 2'd0, 2'd0, 4'd1, 3'd0) :
            (c == 1) ? mk_ctrl(4, 2'd0, 2'd0, 2'd0, 4'd1, 3'd5) :
                       mk_ctrl(4, 2'd2, 2'd0, 2'd2, 4'd1, 3'd1);
      cfg_write(1'b0, 2'd2, bad);
      e0 = n_err;
      pulse_start();
      pulse_sw();
      idle(8);
      chk(n_err == e0 + 1, "R9 error pulse", 32'(n_err - e0), 32'h1);
      chk(chan_en == 1'b0, "R9 channel disabled", 32'(chan_en), 32'h0);
      tbl_read(1'b0, 2'd2, rd);
      chk(rd == bad, "R9 control word untouched", rd, bad);
    end

    // T7: requests while disabled (R10)
    setup(1'b0, 32'hB00, 32'hB80, 3, 2'd0, 2'd0, 2'd0, 4'd3, 3'd1);
    periph_req = 1'b1;
    pulse_sw();
    idle(20);
    periph_req = 1'b0;
    tbl_read(1'b0, 2'd2, rd);
    chk(rd == mk_ctrl(3, 2'd0, 2'd0, 2'd0, 4'd3, 3'd1), "R10 table unchanged while off",
        rd, mk_ctrl(3, 2'd0, 2'd0, 2'd0, 4'd3, 3'd1));
    chk(chan_en == 1'b0, "R10 still disabled", 32'(chan_en), 32'h0);
    pulse_sw();
    pulse_start();
    idle(20);
    chk(exp_q.size() == 0 && chan_en == 1'b1, "R10 earlier software pulse forgotten",
        32'(chan_en), 32'h1);
    tbl_read(1'b0, 2'd2, rd);
    chk(rd[13:4] == 10'd2, "R10 count untouched", 32'(rd[13:4]), 32'd2);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule